// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers eight event indications into one status byte, gates that byte with a host-written enable byte, and drives an active-low interrupt request. Most flags are sticky: a one-cycle event pulse sets the flag and it stays set until the host clears it. Two flags behave differently. The energy half-full flag is produced inside the block from a rising edge of the energy register's top bit. The zero-crossing flag is not stored at all, because it shows the live comparator level.

The host reaches the block through simple write and read strobes with an address. The status byte can be read at two addresses. One read has no side effect. The other returns the status and then wipes every stored flag. A flag that marks the end of a hardware or software reset is reported in status but can never pull the interrupt line low, whatever its enable bit holds.

Top module: `irq_status_ctrl`

## Requirements
- R1: After hardware reset the status byte reads 0x40, the enable byte (address 0x03) reads 0x00 and irqN is high.
- R2: A one-cycle pulse on evtPulse bit 1 (sag), 2 (line-cycle end), 3 (waveform sample), 5 (temperature ready) or 7 (energy overflow) sets the status bit of the same position, and that bit stays set until a clearing read or a reset.
- R3: Status bit 0 (energy half-full) is set only by a 0-to-1 transition of energyMsb. A steady high level does not set it again. Pulses on evtPulse bits 0, 4 and 6 have no effect on the status byte.
- R4: Status bit 4 shows the present value of zxLevel and is never stored.
- R5: irqN is low while any status bit other than bit 6 is 1 with its enable bit also 1. It is high again as soon as no such bit remains.
- R6: Status bit 6 (reset done) never drives irqN low, even with enable byte 0xFF.
- R7: A read of address 0x04 returns the status byte and leaves every flag unchanged.
- R8: A read of address 0x05 returns the status byte as it was before the read and clears every stored flag. An event that arrives in the same cycle as the clearing read stays set.
- R9: The enable byte is written and read at address 0x03. Writes to addresses 0x04 and 0x05 change nothing.
- R10: A pulse on softRst clears all stored flags and the enable byte, then sets status bit 6.
- R11: Read data is registered and is valid in the cycle after the read strobe. A read of any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| softRst | input | 1 | Synchronous software reset pulse |
| evtPulse | input | 8 | Per-bit one-cycle event pulses, positions as in the status byte |
| energyMsb | input | 1 | Most significant bit of the energy register |
| zxLevel | input | 1 | Live zero-crossing level |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| addr | input | 4 | Host register address |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Registered read data |
| irqN | output | 1 | Active-low interrupt request |

## Verification
A stored flag is set at the clock edge that samples its pulse or its energyMsb edge. irqN follows from flip-flops through gates only, so it is correct in the same cycle as that edge, and it follows zxLevel with no clock delay at all. Read data is registered, which makes it valid one edge after the read strobe. The bench drives every input at the falling edge and samples at the next falling edge, which places each check exactly one sampling edge after its stimulus. The clearing read and its effect are checked separately: the returned byte is checked first, and a plain read that follows shows the state after the clear.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int HALF_BIT = 0;
  localparam int ZX_BIT   = 4;
  localparam int RST_BIT  = 6;

  typedef struct packed {
    logic wrMask;
    logic rdPlain;
    logic rdClear;
    logic rdMask;
    logic rdOther;
    logic swReset;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MASK_ADDR  = 3,
  parameter int PLAIN_ADDR = 4,
  parameter int CLEAR_ADDR = 5
) (
  input  logic              softRst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(MASK_ADDR);
  localparam logic [ADDR_W-1:0] PLAIN_A = ADDR_W'(PLAIN_ADDR);
  localparam logic [ADDR_W-1:0] CLEAR_A = ADDR_W'(CLEAR_ADDR);

  logic hitMask, hitPlain, hitClear;

  always_comb begin
    hitMask  = (addr == MASK_A);
    hitPlain = (addr == PLAIN_A);
    hitClear = (addr == CLEAR_A);
    strobes.swReset = softRst;
    strobes.wrMask  = wrEn & hitMask;
    strobes.rdMask  = rdEn & hitMask;
    strobes.rdPlain = rdEn & hitPlain;
    strobes.rdClear = rdEn & hitClear;
    strobes.rdOther = rdEn & ~(hitMask | hitPlain | hitClear);
  end
endmodule

// File: rtl/irq_stat_datapath.sv
module irq_stat_datapath
  import irq_stat_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t st,
  input  logic [W-1:0] evtPulse,
  input  logic        energyMsb,
  input  logic        zxLevel,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic        irqN
);
  localparam logic [W-1:0] RST_ONLY  = W'(1) << RST_BIT;
  localparam logic [W-1:0] IRQ_ALLOW = ~RST_ONLY;

  logic [W-1:0] latchedQ, maskQ, newEvt, statusView, rdDataQ;
  logic         msbPrev;

  // Each status position is one of four kinds: edge-born, live, reset-born, or pulse-born
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == HALF_BIT) begin : g_edge
      assign newEvt[i]     = energyMsb & ~msbPrev;
      assign statusView[i] = latchedQ[i];
    end else if (i == ZX_BIT) begin : g_live
      assign newEvt[i]     = 1'b0;
      assign statusView[i] = zxLevel;
    end else if (i == RST_BIT) begin : g_rst
      assign newEvt[i]     = 1'b0;
      assign statusView[i] = latchedQ[i];
    end else begin : g_pulse
      assign newEvt[i]     = evtPulse[i];
      assign statusView[i] = latchedQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedQ <= RST_ONLY;
      maskQ    <= '0;
      msbPrev  <= 1'b0;
    end else if (st.swReset) begin
      latchedQ <= RST_ONLY;
      maskQ    <= '0;
      msbPrev  <= energyMsb;
    end else begin
      if (st.rdClear) latchedQ <= newEvt;
      else            latchedQ <= latchedQ | newEvt;
      if (st.wrMask)  maskQ    <= wrData;
      msbPrev <= energyMsb;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (st.rdPlain || st.rdClear) begin
      rdDataQ <= statusView;
    end else if (st.rdMask) begin
      rdDataQ <= maskQ;
    end else if (st.rdOther) begin
      rdDataQ <= '0;
    end
  end

  assign rdData = rdDataQ;
  assign irqN   = ~|(statusView & maskQ & IRQ_ALLOW);

  // R7
  plain_read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdPlain && !st.swReset && newEvt == '0) |=> (latchedQ == $past(latchedQ)));

  // R8
  clear_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdClear && !st.swReset) |=> ((latchedQ & ~$past(newEvt)) == '0));

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.swReset |=> (latchedQ == RST_ONLY && maskQ == '0));

  // R6
  reset_flag_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchedQ == RST_ONLY && !zxLevel) |-> irqN);

  // R3
  half_full_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(energyMsb) && !st.swReset) |=> latchedQ[HALF_BIT]);

  // R11
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdPlain && !st.swReset) |=> (rdData == $past(statusView)));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic [STAT_W-1:0] evtPulse,
  input  logic              energyMsb,
  input  logic              zxLevel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] rdData,
  output logic              irqN
);
  ctlStrobes_t strobes;

  irq_stat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .softRst (softRst),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .strobes (strobes)
  );

  irq_stat_datapath #(.W(STAT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobes),
    .evtPulse  (evtPulse),
    .energyMsb (energyMsb),
    .zxLevel   (zxLevel),
    .wrData    (wrData),
    .rdData    (rdData),
    .irqN      (irqN)
  );
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN, softRst, energyMsb, zxLevel, wrEn, rdEn;
  logic [7:0] evtPulse, wrData, rdData;
  logic [3:0] addr;
  logic       irqN;
  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .evtPulse(evtPulse),
    .energyMsb(energyMsb), .zxLevel(zxLevel), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqN(irqN)
  );

  // {event pulses, enable byte, expected status, expected irqN}
  localparam logic [24:0] VEC [8] = '{
    {8'h02, 8'h02, 8'h02, 1'b0},
    {8'h02, 8'h00, 8'h02, 1'b1},
    {8'h80, 8'h7F, 8'h80, 1'b1},
    {8'hA0, 8'h20, 8'hA0, 1'b0},
    {8'h51, 8'hFF, 8'h00, 1'b1},
    {8'h0C, 8'h08, 8'h0C, 1'b0},
    {8'hFF, 8'hBF, 8'hAE, 1'b0},
    {8'h00, 8'hFF, 8'h00, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] v);
    wrEn = 1'b1; addr = a; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseEvt(input logic [7:0] m);
    evtPulse = m;
    @(negedge clk);
    evtPulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rstN = 1'b0; softRst = 0; energyMsb = 0; zxLevel = 0;
    wrEn = 0; rdEn = 0; addr = '0; wrData = '0; evtPulse = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irqN", {7'b0, irqN}, 8'h01);
    busRead(4'h4, d); check("R1 status", d, 8'h40);
    busRead(4'h3, d); check("R1 enable", d, 8'h00);

    // R6 reset flag with all enables
    busWrite(4'h3, 8'hFF);
    check("R6 irqN", {7'b0, irqN}, 8'h01);
    busRead(4'h5, d); check("R8 clear returns reset flag", d, 8'h40);
    busRead(4'h4, d); check("R8 reset flag cleared", d, 8'h00);

    // vector table: R2 R3 R5 R7 R8 R9
    for (int i = 0; i < 8; i++) begin
      busWrite(4'h3, VEC[i][16:9]);
      pulseEvt(VEC[i][24:17]);
      check($sformatf("R5 vec%0d irqN", i), {7'b0, irqN}, {7'b0, VEC[i][0]});
      busRead(4'h4, d); check($sformatf("R2 vec%0d status", i), d, VEC[i][8:1]);
      busRead(4'h4, d); check($sformatf("R7 vec%0d plain again", i), d, VEC[i][8:1]);
      busRead(4'h3, d); check($sformatf("R9 vec%0d enable", i), d, VEC[i][16:9]);
      busRead(4'h5, d); check($sformatf("R8 vec%0d clear read", i), d, VEC[i][8:1]);
      check($sformatf("R5 vec%0d irq released", i), {7'b0, irqN}, 8'h01);
      busRead(4'h4, d); check($sformatf("R8 vec%0d after clear", i), d, 8'h00);
    end

    // R4 live zero crossing
    busWrite(4'h3, 8'h10);
    zxLevel = 1'b1;
    #1 check("R4 irq follows zx", {7'b0, irqN}, 8'h00);
    @(negedge clk);
    busRead(4'h4, d); check("R4 zx high", d, 8'h10);
    zxLevel = 1'b0;
    #1 check("R4 irq release", {7'b0, irqN}, 8'h01);
    @(negedge clk);
    busRead(4'h5, d); check("R4 zx low", d, 8'h00);

    // R3 half-full edge, no retrigger on steady high
    busWrite(4'h3, 8'h01);
    energyMsb = 1'b1;
    @(negedge clk);
    check("R3 half irq", {7'b0, irqN}, 8'h00);
    busRead(4'h5, d); check("R3 half set", d, 8'h01);
    repeat (3) @(negedge clk);
    busRead(4'h4, d); check("R3 no retrigger", d, 8'h00);
    energyMsb = 1'b0;
    @(negedge clk);

    // R8 event during clearing read
    pulseEvt(8'h80);
    rdEn = 1'b1; addr = 4'h5; evtPulse = 8'h02;
    @(negedge clk);
    rdEn = 1'b0; evtPulse = '0;
    check("R8 clear returns old", rdData, 8'h80);
    busRead(4'h4, d); check("R8 same-cycle event kept", d, 8'h02);

    // R9 writes to status addresses ignored
    busWrite(4'h4, 8'hFF);
    busWrite(4'h5, 8'hFF);
    busRead(4'h4, d); check("R9 status write ignored", d, 8'h02);
    busRead(4'h3, d); check("R9 enable unchanged", d, 8'h01);

    // R11 unmapped read
    busRead(4'h7, d); check("R11 unmapped", d, 8'h00);

    // R10 software reset
    busWrite(4'h3, 8'hFF);
    pulseEvt(8'h20);
    check("R10 irq before", {7'b0, irqN}, 8'h00);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    check("R10 irq after", {7'b0, irqN}, 8'h01);
    busRead(4'h4, d); check("R10 status", d, 8'h40);
    busRead(4'h3, d); check("R10 enable", d, 8'h00);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule